// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block arbitrates service requests across eight priority levels, with level 0 the most urgent. Four hardware request lines feed levels 0 to 3. Software commands post requests on levels 4 to 7. The block holds a request register and a stack of active-level bits. When a pending request outranks every active level, the block offers a break to the CPU at the next instruction boundary. When the CPU acknowledges, that level is marked active.

The CPU drives the block with a single command port. A set command carries an 18-bit control word. That word enables or disables the system, posts maintenance and software requests, and can raise the running priority. A debreak command releases the most urgent active level. A skip command tests the block's state against a control word and returns the result in the same cycle. While the system is disabled, hardware lines are steered to a separate program-interrupt output. Taking that program interrupt marks level 3 active.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the system is disabled, no level is active, no request is pending and `brk_req_o` is low.
- R2: A request on level n can be chosen only while the system is enabled and levels 0..n are all inactive; among eligible requests the lowest-numbered level is chosen.
- R3: When `boundary_i` is high and some request is eligible, `brk_req_o` rises in the next cycle with the chosen level on `brk_lvl_o`. It holds with that level until `brk_ack_i`, or drops once that level stops being eligible. An acknowledge marks the level active and lowers `brk_req_o` in the following cycle.
- R4: A debreak clears the lowest-numbered active bit and the request bit of that level; with no level active it changes nothing.
- R5: Control word bit k is `cmd_word_i[17-k]`. In a set command, bit 0 writes the enable. Bits 2..5 set requests on levels 0..3, and bits 6..9 set requests on levels 4..7. Request bits stay set until a debreak clears them.
- R6: In a set command, bits 10..17 select a raise to levels 0..7, and the lowest selected level is taken. The raise marks that level active only when levels 0..n are all inactive; otherwise it is ignored. A raise never issues a break.
- R7: A skip command drives `skip_o` high in the same cycle when bit 0 is set and the system is enabled. It is also high when, for any n, bit 10+n is set and levels 0..n are all inactive.
- R8: During a break, `brk_vec_o` is 32+(n-4) (octal 40..43) for software level n. For hardware level n it is `hw_vec_i[15n+14:15n]`.
- R9: While disabled, any high `hw_req_i` line drives `pi_req_o` high in the same cycle and sets no request bit. While enabled, `pi_req_o` is low and the lines set request bits 0..3.
- R10: `pi_take_i` marks level 3 active in the next cycle.
- R11: An acknowledge and a debreak in the same cycle both take effect. The debreak releases the most urgent level that was active before that cycle, and the granted level stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 4 | Hardware request lines for levels 0..3 |
| hw_vec_i | input | 60 | Entry addresses of hardware levels, 15 bits per level |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 none, 1 set, 2 debreak, 3 skip test |
| cmd_word_i | input | 18 | Control word, bit 0 at the MSB |
| skip_o | output | 1 | Skip test result |
| boundary_i | input | 1 | Instruction boundary strobe |
| brk_req_o | output | 1 | Break request to CPU |
| brk_ack_i | input | 1 | CPU accepts the break |
| brk_lvl_o | output | 3 | Level of the offered break |
| brk_vec_o | output | 15 | Entry address of the offered break |
| pi_req_o | output | 1 | Program-interrupt request while disabled |
| pi_take_i | input | 1 | CPU takes the program interrupt |

## Verification
The CPU's break acknowledge and a debreak command can fall in the same cycle. The acknowledge pushes a new active bit, while the debreak pops the most urgent old one. The directed sequence provokes this while level 2 is raised and a level 1 break is pending. Skip probes then show that level 1 is still active and that level 2 is gone. A reference model exercises the same collision many times over random traffic with commands, strobes and acknowledges, and compares every output cycle by cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_LVL = 8;
  localparam int NUM_HW  = 4;
  localparam int VEC_W   = 15;
  localparam int SW_BASE = 32;  // octal 40

  // control word field positions (bit 0 = MSB)
  localparam int EN_BIT    = 0;
  localparam int REQ_BIT   = 2;
  localparam int RAISE_BIT = REQ_BIT + NUM_LVL;
  localparam int CW_W      = RAISE_BIT + NUM_LVL;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_DBK  = 2'd2,
    OP_SKIP = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/prio_irq_req_reg.sv
module prio_irq_req_reg #(
  parameter int NLVL = 8,
  parameter int NHW  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [NHW-1:0]          hw_req_i,
  input  logic [NLVL-1:0]         set_i,
  input  logic                    clr_vld_i,
  input  logic [$clog2(NLVL)-1:0] clr_lvl_i,
  output logic [NLVL-1:0]         rr_o
);
  logic [NLVL-1:0] rr_q, hw_mask, clr_mask;

  always_comb begin
    hw_mask = '0;
    hw_mask[NHW-1:0] = en_i ? hw_req_i : '0;
    clr_mask = '0;
    if (clr_vld_i) clr_mask[clr_lvl_i] = 1'b1;
  end

  // new requests win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rr_q <= '0;
    else         rr_q <= (rr_q & ~clr_mask) | set_i | hw_mask;

  assign rr_o = rr_q;

  p_req_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_vld_i |=> ((rr_q & $past(rr_q)) == $past(rr_q)));
endmodule

// File: rtl/prio_irq_level_stack.sv
module prio_irq_level_stack #(
  parameter int NLVL   = 8,
  parameter int PI_LVL = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dbk_i,
  input  logic                    grant_vld_i,
  input  logic [$clog2(NLVL)-1:0] grant_lvl_i,
  input  logic [NLVL-1:0]         raise_sel_i,
  input  logic                    pi_take_i,
  output logic [NLVL-1:0]         clear_o,
  output logic                    dbk_vld_o,
  output logic [$clog2(NLVL)-1:0] dbk_lvl_o
);
  localparam int LW = $clog2(NLVL);

  logic [NLVL-1:0] act_q, act_d, clr;
  logic            top_vld, rz_vld, raise_ok;
  logic [LW-1:0]   top_lvl, rz_lvl;

  // clr[n]: levels 0..n all inactive
  for (genvar g = 0; g < NLVL; g++) begin : g_clr
    if (g == 0) begin : g_first
      assign clr[g] = ~act_q[g];
    end else begin : g_rest
      assign clr[g] = clr[g-1] & ~act_q[g];
    end
  end

  always_comb begin
    top_vld = 1'b0;
    top_lvl = '0;
    rz_vld  = 1'b0;
    rz_lvl  = '0;
    for (int n = NLVL - 1; n >= 0; n--) begin
      if (act_q[n]) begin
        top_vld = 1'b1;
        top_lvl = LW'(n);
      end
      if (raise_sel_i[n]) begin
        rz_vld = 1'b1;
        rz_lvl = LW'(n);
      end
    end
    raise_ok = rz_vld & clr[rz_lvl];

    act_d = act_q;
    if (dbk_i && top_vld) act_d[top_lvl] = 1'b0;
    if (grant_vld_i)      act_d[grant_lvl_i] = 1'b1;
    if (raise_ok)         act_d[rz_lvl] = 1'b1;
    if (pi_take_i)        act_d[PI_LVL] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;

  assign clear_o   = clr;
  assign dbk_vld_o = dbk_i & top_vld;
  assign dbk_lvl_o = top_lvl;

  p_grant_marks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_i |=> act_q[$past(grant_lvl_i)]);

  p_dbk_releases_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbk_i && top_vld && !(pi_take_i && top_lvl == LW'(PI_LVL))
     && !(grant_vld_i && grant_lvl_i == top_lvl))
    |=> !act_q[$past(top_lvl)]);

  p_only_dbk_lowers_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbk_i |=> ((act_q & $past(act_q)) == $past(act_q)));
endmodule

// File: rtl/prio_irq_break_ctl.sv
module prio_irq_break_ctl #(
  parameter int NLVL    = 8,
  parameter int NHW     = 4,
  parameter int VEC_W   = 15,
  parameter int SW_BASE = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NLVL-1:0]         elig_i,
  input  logic                    boundary_i,
  input  logic                    ack_i,
  input  logic [NHW*VEC_W-1:0]    hw_vec_i,
  output logic                    brk_req_o,
  output logic [$clog2(NLVL)-1:0] brk_lvl_o,
  output logic [VEC_W-1:0]        brk_vec_o,
  output logic                    grant_vld_o,
  output logic [$clog2(NLVL)-1:0] grant_lvl_o
);
  localparam int LW = $clog2(NLVL);

  logic             req_q, any_elig, grant;
  logic [LW-1:0]    lvl_q, best;
  logic [VEC_W-1:0] vec_tab [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_vec
    if (g < NHW) begin : g_hw
      assign vec_tab[g] = hw_vec_i[g*VEC_W +: VEC_W];
    end else begin : g_sw
      assign vec_tab[g] = VEC_W'(SW_BASE + g - NHW);
    end
  end

  always_comb begin
    best = '0;
    for (int n = NLVL - 1; n >= 0; n--)
      if (elig_i[n]) best = LW'(n);
  end

  assign any_elig = |elig_i;
  assign grant    = req_q & ack_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      req_q <= 1'b0;
      lvl_q <= '0;
    end else if (grant) begin
      req_q <= 1'b0;
    end else if (req_q && !elig_i[lvl_q]) begin
      req_q <= 1'b0;  // withdrawn: outranked or disabled
    end else if (!req_q && boundary_i && any_elig) begin
      req_q <= 1'b1;
      lvl_q <= best;
    end

  assign brk_req_o   = req_q;
  assign brk_lvl_o   = lvl_q;
  assign brk_vec_o   = req_q ? vec_tab[lvl_q] : '0;
  assign grant_vld_o = grant;
  assign grant_lvl_o = lvl_q;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i && elig_i[lvl_q]) |=> (req_q && $stable(lvl_q)));

  p_ack_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i) |=> !req_q);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_LVL_P = NUM_LVL,
  parameter int NUM_HW_P  = NUM_HW,
  parameter int VEC_W_P   = VEC_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_HW_P-1:0]          hw_req_i,
  input  logic [NUM_HW_P*VEC_W_P-1:0]  hw_vec_i,
  input  logic                         cmd_valid_i,
  input  logic [1:0]                   cmd_op_i,
  input  logic [2*NUM_LVL_P+1:0]       cmd_word_i,
  output logic                         skip_o,
  input  logic                         boundary_i,
  output logic                         brk_req_o,
  input  logic                         brk_ack_i,
  output logic [$clog2(NUM_LVL_P)-1:0] brk_lvl_o,
  output logic [VEC_W_P-1:0]           brk_vec_o,
  output logic                         pi_req_o,
  input  logic                         pi_take_i
);
  localparam int LW    = $clog2(NUM_LVL_P);
  localparam int W     = 2 * NUM_LVL_P + 2;
  localparam int RAISE = REQ_BIT + NUM_LVL_P;

  cmd_op_e         op;
  logic            is_set, is_dbk, is_skip, en_q, unused_bit;
  logic [NUM_LVL_P-1:0] set_mask, raise_raw, raise_sel, clr, rr, elig;
  logic            dbk_vld, grant_vld;
  logic [LW-1:0]   dbk_lvl, grant_lvl;

  assign op      = cmd_op_e'(cmd_op_i);
  assign is_set  = cmd_valid_i && op == OP_SET;
  assign is_dbk  = cmd_valid_i && op == OP_DBK;
  assign is_skip = cmd_valid_i && op == OP_SKIP;
  assign unused_bit = cmd_word_i[W-2];

  always_comb begin
    for (int n = 0; n < NUM_LVL_P; n++) begin
      set_mask[n]  = is_set & cmd_word_i[W-1-(REQ_BIT+n)];
      raise_raw[n] = cmd_word_i[W-1-(RAISE+n)];
    end
  end
  assign raise_sel = is_set ? raise_raw : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     en_q <= 1'b0;
    else if (is_set) en_q <= cmd_word_i[W-1-EN_BIT];

  prio_irq_req_reg #(.NLVL(NUM_LVL_P), .NHW(NUM_HW_P)) u_req (
    .clk_i, .rst_ni,
    .en_i      (en_q),
    .hw_req_i  (hw_req_i),
    .set_i     (set_mask),
    .clr_vld_i (dbk_vld),
    .clr_lvl_i (dbk_lvl),
    .rr_o      (rr)
  );

  prio_irq_level_stack #(.NLVL(NUM_LVL_P), .PI_LVL(NUM_HW_P - 1)) u_stack (
    .clk_i, .rst_ni,
    .dbk_i       (is_dbk),
    .grant_vld_i (grant_vld),
    .grant_lvl_i (grant_lvl),
    .raise_sel_i (raise_sel),
    .pi_take_i   (pi_take_i),
    .clear_o     (clr),
    .dbk_vld_o   (dbk_vld),
    .dbk_lvl_o   (dbk_lvl)
  );

  assign elig = en_q ? (rr & clr) : '0;

  prio_irq_break_ctl #(
    .NLVL(NUM_LVL_P), .NHW(NUM_HW_P), .VEC_W(VEC_W_P), .SW_BASE(SW_BASE)
  ) u_brk (
    .clk_i, .rst_ni,
    .elig_i      (elig),
    .boundary_i  (boundary_i),
    .ack_i       (brk_ack_i),
    .hw_vec_i    (hw_vec_i),
    .brk_req_o   (brk_req_o),
    .brk_lvl_o   (brk_lvl_o),
    .brk_vec_o   (brk_vec_o),
    .grant_vld_o (grant_vld),
    .grant_lvl_o (grant_lvl)
  );

  assign skip_o   = is_skip & ((cmd_word_i[W-1-EN_BIT] & en_q) | |(raise_raw & clr));
  assign pi_req_o = ~en_q & |hw_req_i;

  p_pi_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pi_req_o |-> !en_q);

  p_no_brk_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !brk_req_o) |=> !brk_req_o);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/100ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hw_req = '0;
  logic [59:0] hw_vec;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [17:0] cmd_word = '0;
  logic        boundary = 1'b0, ack = 1'b0, pi_take = 1'b0;
  logic        skip_o, brk_req_o, pi_req_o;
  logic [2:0]  brk_lvl_o;
  logic [14:0] brk_vec_o;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_rr, m_act;
  logic       m_en, m_breq, skip_seen, pi_seen;
  logic [2:0] m_lvl;

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .hw_vec_i(hw_vec),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_word_i(cmd_word),
    .skip_o(skip_o), .boundary_i(boundary), .brk_req_o(brk_req_o),
    .brk_ack_i(ack), .brk_lvl_o(brk_lvl_o), .brk_vec_o(brk_vec_o),
    .pi_req_o(pi_req_o), .pi_take_i(pi_take)
  );

  function automatic logic [14:0] hv(int n);
    return 15'(15'o1000 + 3 * n);
  endfunction
  function automatic logic [17:0] mk(int k);
    return 18'(1) << (17 - k);
  endfunction
  function automatic logic cw(logic [17:0] w, int k);
    return w[17-k];
  endfunction
  function automatic logic above(logic [7:0] a, int n);
    for (int i = 0; i <= n; i++) if (a[i]) return 1'b0;
    return 1'b1;
  endfunction
  function automatic logic [14:0] exp_vec(logic [2:0] l);
    return (l < 4) ? hv(int'(l)) : 15'(32 + int'(l) - 4);
  endfunction

  task automatic chk(logic ok, string tag, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] el, na, nr;
    int best, top, rz;
    logic grant;
    for (int n = 0; n < 8; n++) el[n] = m_en & m_rr[n] & above(m_act, n);
    best = -1;
    for (int n = 7; n >= 0; n--) if (el[n]) best = n;
    grant = m_breq & ack;
    na = m_act;
    nr = m_rr;
    if (cmd_valid && cmd_op == 2'd2) begin
      top = -1;
      for (int n = 7; n >= 0; n--) if (m_act[n]) top = n;
      if (top >= 0) begin na[top] = 1'b0; nr[top] = 1'b0; end
    end
    if (grant) na[m_lvl] = 1'b1;
    if (cmd_valid && cmd_op == 2'd1) begin
      rz = -1;
      for (int n = 7; n >= 0; n--) if (cw(cmd_word, 10 + n)) rz = n;
      if (rz >= 0 && above(m_act, rz)) na[rz] = 1'b1;
      for (int n = 0; n < 8; n++) if (cw(cmd_word, 2 + n)) nr[n] = 1'b1;
    end
    if (pi_take) na[3] = 1'b1;
    if (m_en) nr[3:0] = nr[3:0] | hw_req;
    if (grant) m_breq = 1'b0;
    else if (m_breq && !el[m_lvl]) m_breq = 1'b0;
    else if (!m_breq && boundary && best >= 0) begin
      m_breq = 1'b1;
      m_lvl  = 3'(best);
    end
    if (cmd_valid && cmd_op == 2'd1) m_en = cw(cmd_word, 0);
    m_act = na;
    m_rr  = nr;
  endtask

  // inputs set at negedge; combinational outputs checked, then one edge
  task automatic tick();
    logic es;
    #0.5;
    es = 1'b0;
    if (cmd_valid && cmd_op == 2'd3) begin
      es = cw(cmd_word, 0) & m_en;
      for (int n = 0; n < 8; n++) if (cw(cmd_word, 10 + n) && above(m_act, n)) es = 1'b1;
    end
    skip_seen = skip_o;
    pi_seen   = pi_req_o;
    chk(skip_o == es, "R7 skip_o", int'(skip_o), int'(es));
    chk(pi_req_o == (!m_en && |hw_req), "R9 pi_req_o", int'(pi_req_o), int'(!m_en && |hw_req));
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(brk_req_o == m_breq, "R3 brk_req_o", int'(brk_req_o), int'(m_breq));
    if (m_breq && brk_req_o) begin
      chk(brk_lvl_o == m_lvl, "R2 brk_lvl_o", int'(brk_lvl_o), int'(m_lvl));
      chk(brk_vec_o == exp_vec(m_lvl), "R8 brk_vec_o", int'(brk_vec_o), int'(exp_vec(m_lvl)));
    end
  endtask

  task automatic cmd(logic [1:0] op, logic [17:0] w);
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
    tick();
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_word = '0;
  endtask

  task automatic probe(int k, logic exp, string tag);
    cmd(2'd3, mk(k));
    chk(skip_seen == exp, tag, int'(skip_seen), int'(exp));
  endtask

  initial begin
    for (int n = 0; n < 4; n++) hw_vec[n*15 +: 15] = hv(n);
  end

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_rr = '0; m_act = '0; m_en = 1'b0; m_breq = 1'b0; m_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(brk_req_o == 1'b0, "R1 brk_req_o", int'(brk_req_o), 0);
    chk(pi_req_o == 1'b0, "R1 pi_req_o", int'(pi_req_o), 0);
    probe(0, 1'b0, "R1 disabled after reset");
    probe(17, 1'b1, "R1 no level active");
    // R5: enable
    cmd(2'd1, mk(0));
    probe(0, 1'b1, "R5 enable bit");
    // R4: debreak with nothing active
    cmd(2'd2, '0);
    probe(17, 1'b1, "R4 empty debreak");
    // software request on level 5
    cmd(2'd1, mk(0) | mk(7));
    boundary = 1'b1; tick(); boundary = 1'b0;
    chk(brk_lvl_o == 3'd5, "R5 sw request level", int'(brk_lvl_o), 5);
    chk(brk_vec_o == 15'd33, "R8 sw vector", int'(brk_vec_o), 33);
    ack = 1'b1; tick(); ack = 1'b0;
    chk(brk_req_o == 1'b0, "R3 ack clears request", int'(brk_req_o), 0);
    probe(17, 1'b0, "R3 level 5 active");
    probe(14, 1'b1, "R3 levels 0..4 inactive");
    // R6: raise to 6 ignored under 5
    cmd(2'd1, mk(0) | mk(16));
    cmd(2'd2, '0);
    probe(17, 1'b1, "R6 lower raise ignored");
    // R6: raise to 2
    cmd(2'd1, mk(0) | mk(12));
    chk(brk_req_o == 1'b0, "R6 raise gives no break", int'(brk_req_o), 0);
    probe(11, 1'b1, "R6 levels 0..1 inactive");
    probe(12, 1'b0, "R6 level 2 raised");
    // hardware level 1 preempts
    hw_req = 4'b0010; tick(); hw_req = '0;
    boundary = 1'b1; tick(); boundary = 1'b0;
    chk(brk_lvl_o == 3'd1, "R2 hw level 1 chosen", int'(brk_lvl_o), 1);
    chk(brk_vec_o == hv(1), "R8 hw vector", int'(brk_vec_o), int'(hv(1)));
    // R11: acknowledge and debreak together
    ack = 1'b1; cmd(2'd2, '0); ack = 1'b0;
    probe(11, 1'b0, "R11 granted level kept");
    cmd(2'd2, '0);
    probe(17, 1'b1, "R11 old top released");
    // R9: disabled routing
    cmd(2'd1, '0);
    hw_req = 4'b0100; tick(); hw_req = '0;
    chk(pi_seen == 1'b1, "R9 pi_req_o while disabled", int'(pi_seen), 1);
    cmd(2'd1, mk(0));
    boundary = 1'b1; tick(); boundary = 1'b0;
    chk(brk_req_o == 1'b0, "R9 line not latched while disabled", int'(brk_req_o), 0);
    // R10: program interrupt taken
    pi_take = 1'b1; tick(); pi_take = 1'b0;
    probe(13, 1'b0, "R10 level 3 active");
    probe(12, 1'b1, "R10 levels 0..2 inactive");
    cmd(2'd2, '0);
    probe(17, 1'b1, "R4 level 3 released");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [17:0] w;
      r = int'($urandom_range(0, 99));
      w = 18'($urandom);
      w[17-1] = 1'b0;
      if (r < 10) begin
        cmd_valid = 1'b1; cmd_op = 2'd1;
        w[17]   = ($urandom_range(0, 9) != 0);
        w[15:12] = ($urandom_range(0, 7) == 0) ? w[15:12] : 4'b0;
        w[7:0]   = w[7:0] & 8'($urandom);
        cmd_word = w;
      end else if (r < 22) begin
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_word = w;
      end else if (r < 35) begin
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_word = w;
      end
      hw_req   = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'b0;
      boundary = ($urandom_range(0, 2) == 0);
      ack      = brk_req_o && ($urandom_range(0, 1) == 0);
      pi_take  = ($urandom_range(0, 60) == 0);
      tick();
      cmd_valid = 1'b0; cmd_op = '0; cmd_word = '0;
      hw_req = '0; boundary = 1'b0; ack = 1'b0; pi_take = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule